// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Event Counters

This block gathers a set of level-sensitive interrupt request lines, 32 by default, into one request output for a processor. Each line first passes through a two-flop synchroniser. It then sets its bit in a live line-state register. Every cycle, the line-state register is ORed into a sticky pending register. The output is high while any pending bit is also enabled in the mask register.

Software reaches the block through a plain register port. The port has a write strobe, an address and write data, and a read data bus that follows the address with no wait state. Software sets the mask, reads the pending and live-state registers, and clears pending bits with write-one-to-clear writes. A pending bit whose line is still high cannot be cleared, because the refresh from line state sets it again in the same cycle.

Each line also has a counter. It counts rising transitions of the synchronised level and wraps modulo 2^32. There is no data stream in this block, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the following are all zero: mask (address 0), pending (address 1), line state (address 2) and every counter. The output `irq_o` is low.
- R2: Bit n of the line-state register (address 2) follows input line n. A change on the line appears on that register three clock edges after it is applied: two synchroniser flops, then the register itself.
- R3: Bit n of the pending register (address 1) is set one edge after line-state bit n is set. It stays set after the line falls.
- R4: A write to address 1 clears each pending bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R5: A pending bit whose line-state bit is 1 stays set after a clear write to that bit.
- R6: `irq_o` is high exactly when the bitwise AND of pending and mask is non-zero. The mask reads back at address 0 as last written.
- R7: A write to the mask at address 0 changes `irq_o` after the clock edge that captures the write, and not before.
- R8: The counter for line n increments by one on each rising transition of line-state bit n. A line held high adds nothing more, and other lines' counters stay unchanged.
- R9: The counter for line n reads at address 32+n. Writes to counter addresses or to address 2 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 32 | Level-sensitive interrupt request lines |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 6 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
Two functions can act on the same pending bit in the same cycle: the software clear and the refresh from a line that is still high. The bench raises a line, waits for it to reach the pending register, and then writes a clear to that bit while the line is held high. The check is that the bit reads back as still set. After the line is dropped, the same write must clear the bit. The checker also states, for every cycle, that a pending bit whose line-state bit was high in the previous cycle is set.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned REG_MASK  = 0;
  localparam int unsigned REG_PEND  = 1;
  localparam int unsigned REG_LINE  = 2;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_agg_state.sv
module irq_agg_state #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic             mask_we_i,
  input  logic [WIDTH-1:0] mask_wdata_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] line_o,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] line_q, pend_q, mask_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_bits_i : '0;
  assign rise_o  = level_i & ~line_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      line_q <= '0;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      line_q <= level_i;
      pend_q <= (pend_q & ~clr_eff) | line_q;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign line_o = line_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_agg_counters.sv
module irq_agg_counters #(
  parameter int unsigned LINES = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LINES-1:0]       rise_i,
  output logic [LINES*CNT_W-1:0] cnt_o
);
  for (genvar n = 0; n < LINES; n++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (rise_i[n]) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[n*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned ADDR_W   = IDX_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0]        level_sync, line_q, pend_q, mask_q, rise;
  logic [NUM_LINES*DATA_W-1:0] cnt_flat;
  logic                        is_cnt, mask_we, clr_we;
  logic [IDX_W-1:0]            cnt_idx;

  assign is_cnt  = addr_i[ADDR_W-1];
  assign cnt_idx = addr_i[IDX_W-1:0];
  assign mask_we = wr_en_i && (addr_i == ADDR_W'(REG_MASK));
  assign clr_we  = wr_en_i && (addr_i == ADDR_W'(REG_PEND));

  irq_agg_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(irq_lines_i), .sync_o(level_sync)
  );

  irq_agg_state #(.WIDTH(NUM_LINES)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_sync),
    .mask_we_i(mask_we), .mask_wdata_i(wdata_i[NUM_LINES-1:0]),
    .clr_we_i(clr_we), .clr_bits_i(wdata_i[NUM_LINES-1:0]),
    .line_o(line_q), .pend_o(pend_q), .mask_o(mask_q), .rise_o(rise)
  );

  irq_agg_counters #(.LINES(NUM_LINES), .CNT_W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .cnt_o(cnt_flat)
  );

  always_comb begin
    rdata_o = '0;
    if (is_cnt) begin
      if (int'(cnt_idx) < NUM_LINES) rdata_o = cnt_flat[int'(cnt_idx)*DATA_W +: DATA_W];
    end else begin
      case (int'(addr_i))
        REG_MASK: rdata_o = DATA_W'(mask_q);
        REG_PEND: rdata_o = DATA_W'(pend_q);
        REG_LINE: rdata_o = DATA_W'(line_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [31:0]             wdata_i,
  input logic                    irq_o,
  input logic [NUM_LINES-1:0]    line_q,
  input logic [NUM_LINES-1:0]    pend_q,
  input logic [NUM_LINES-1:0]    mask_q,
  input logic [NUM_LINES*32-1:0] cnt_flat
);
  // R3: a pending bit drops only through a clear write
  a_r3_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(1)) |=> ((($past(pend_q)) & ~pend_q) == '0));

  // R5: a line that was high leaves its pending bit set
  a_r5_line_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(line_q) & ~pend_q) == '0));

  // R4: a cleared bit with a low line is gone next cycle
  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(1)) |=>
      ((pend_q & $past(wdata_i[NUM_LINES-1:0]) & ~$past(line_q)) == '0));

  // R7: mask write lands at the next edge
  a_r7_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0)) |=> (mask_q == $past(wdata_i[NUM_LINES-1:0])));

  // R6: output low whenever nothing is pending
  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> !irq_o);

  // R8: counters step by one, only when their line rises
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_cnt_chk
    a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_flat[n*32 +: 32] != $past(cnt_flat[n*32 +: 32])) |->
        ($rose(line_q[n]) && cnt_flat[n*32 +: 32] == $past(cnt_flat[n*32 +: 32]) + 32'd1));
  end
endmodule

bind irq_aggregator irq_agg_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .line_q(line_q), .pend_q(pend_q),
  .mask_q(mask_q), .cnt_flat(cnt_flat)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_aggregator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(6'd0, d);  check("R1 mask", d, 32'h0);
    rd(6'd1, d);  check("R1 pending", d, 32'h0);
    rd(6'd2, d);  check("R1 line", d, 32'h0);
    rd(6'd32, d); check("R1 cnt0", d, 32'h0);
    rd(6'd63, d); check("R1 cnt31", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_line_and_sticky();
    logic [31:0] d;
    @(negedge clk);
    lines = 32'h8000_0008;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(6'd2, d); check("R2 line not yet", d, 32'h0);
    @(negedge clk);
    rd(6'd2, d); check("R2 line after 3 edges", d, 32'h8000_0008);
    rd(6'd1, d); check("R3 pending one edge later", d, 32'h0);
    @(negedge clk);
    rd(6'd1, d); check("R3 pending set", d, 32'h8000_0008);
    check("R6 masked off irq low", {31'b0, irq}, 32'h0);
    lines = 32'h0;
    settle();
    rd(6'd2, d); check("R2 line low", d, 32'h0);
    rd(6'd1, d); check("R3 pending sticky", d, 32'h8000_0008);
    rd(6'd35, d); check("R8 cnt3 one rise", d, 32'd1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    @(negedge clk);
    wr_en = 1'b1; addr = 6'd0; wdata = 32'h0000_0008;
    #1;
    check("R7 irq before edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 irq after edge", {31'b0, irq}, 32'h1);
    rd(6'd0, d); check("R6 mask readback", d, 32'h0000_0008);
    wr(6'd0, 32'h0000_0004);
    check("R6 no overlap irq low", {31'b0, irq}, 32'h0);
    wr(6'd0, 32'h8000_0000);
    check("R6 overlap irq high", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(6'd1, 32'h0000_0008);
    rd(6'd1, d); check("R4 clear bit3", d, 32'h8000_0000);
    wr(6'd1, 32'h0);
    rd(6'd1, d); check("R4 zero write no effect", d, 32'h8000_0000);
    wr(6'd1, 32'h8000_0000);
    rd(6'd1, d); check("R4 clear bit31", d, 32'h0);
    check("R6 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear_while_high();
    logic [31:0] d;
    @(negedge clk);
    lines = 32'h0000_0020;
    settle();
    wr(6'd1, 32'h0000_0020);
    rd(6'd1, d); check("R5 held line keeps pending", d, 32'h0000_0020);
    lines = 32'h0;
    settle();
    wr(6'd1, 32'h0000_0020);
    rd(6'd1, d); check("R5 clears once line low", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); lines = 32'h0000_0080;
      settle();
      @(negedge clk); lines = 32'h0;
      settle();
    end
    rd(6'd39, d); check("R8 cnt7 three rises", d, 32'd3);
    @(negedge clk); lines = 32'h0000_0080;
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(6'd39, d); check("R8 held high counts once", d, 32'd4);
    rd(6'd38, d); check("R8 neighbour untouched", d, 32'd0);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] d;
    wr(6'd39, 32'h0);
    rd(6'd39, d); check("R9 counter write ignored", d, 32'd4);
    wr(6'd2, 32'h0);
    rd(6'd2, d); check("R9 line write ignored", d, 32'h0000_0080);
    rd(6'd1, d); check("R9 pending unaffected", d, 32'h0000_0080);
    rd(6'd0, d); check("R9 mask unaffected", d, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_line_and_sticky();
    t_mask();
    t_w1c();
    t_clear_while_high();
    t_count();
    t_ignored_writes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule